// File: doc/BRIEF.md
# Region Address Translation and Protection Unit

This unit gives a processor core without paging hardware a coarse address map. The 32-bit address space is cut into eight equal 512 MB regions, chosen by the three most significant address bits. Each region has one entry holding a physical region number and a 4-bit attribute. There are two tables of eight entries: instruction fetches look up the instruction table, while loads and stores look up the data table.

A request carries a virtual address and an access kind. The unit reads the selected entry in the same cycle and derives read, write and execute permission from the attribute. It builds the physical address and decides whether the access is granted. All of this is captured in output registers, so the answer appears one cycle after the request. When the access is denied, a cause code tells which kind of access was refused. A write port lets a controller replace any entry of either table at run time.

Top module: `rgn_xlate_unit`

## Requirements
- R1: The region number is req_vaddr[31:29]. Fetch requests (req_kind 2) use the instruction table. Read (0), write (1) and reserved (3) requests use the data table.
- R2: Read and write permission are both granted when the attribute is below 6 and is not 3, or when it equals 14. They are denied for every other attribute.
- R3: Execute permission is granted exactly for attributes 1, 2, 3, 4 and 5.
- R4: rsp_perm bit 0 is read permission, bit 1 is write permission and bit 2 is execute permission.
- R5: A request is granted (rsp_ok=1, rsp_cause=0) when the permission bit for its kind is set. Kind 3 is judged as a read. A denied read gives cause 28, a denied write gives cause 29 and a denied fetch gives cause 20, each with rsp_ok=0.
- R6: rsp_paddr holds the entry's 3-bit physical region number in bits 31:29 and req_vaddr[28:0] in bits 28:0. This holds whether or not the access is granted.
- R7: After reset, entry i of both tables has physical region number i and attribute 2. rsp_valid, rsp_paddr, rsp_perm, rsp_ok and rsp_cause are all 0.
- R8: A write (wr_en=1) stores wr_base and wr_attr into entry wr_idx of the instruction table when wr_itab=1, and of the data table when wr_itab=0. The new entry is used from the next cycle on. A lookup made in the same cycle as the write still sees the old contents.
- R9: A request made in one cycle is answered with rsp_valid=1 in the next cycle. In a cycle after which no request was made, rsp_valid is 0 and the other outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 reserved |
| wr_en | input | 1 | Entry write strobe |
| wr_itab | input | 1 | 1 selects the instruction table, 0 the data table |
| wr_idx | input | 3 | Entry to write |
| wr_base | input | 3 | New physical region number |
| wr_attr | input | 4 | New attribute |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_paddr | output | 32 | Physical address |
| rsp_perm | output | 3 | Permission mask {execute, write, read} |
| rsp_ok | output | 1 | Access granted |
| rsp_cause | output | 6 | Denial cause, 0 when granted |

## Verification
Every attribute value is tried with every access kind, and the two tables are loaded with different attributes. This separates the read/write rule from the execute rule and shows which table each kind reads. Every region is remapped to a distinct physical region, with address offsets that have both high and low bits set. This catches a wrong index, a swapped table or a truncated offset. Further cases check that a lookup made in the same cycle as a write sees the old entry, that back-to-back requests are answered in order, and that idle cycles hold the outputs.

// File: rtl/rgn_pkg.sv
package rgn_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  localparam int PERM_R = 0;
  localparam int PERM_W = 1;
  localparam int PERM_X = 2;

  localparam int CAUSE_FETCH_DENY = 20;
  localparam int CAUSE_LOAD_DENY  = 28;
  localparam int CAUSE_STORE_DENY = 29;

  localparam int ATTR_AT_RESET = 2;
endpackage

// File: rtl/rgn_table.sv
module rgn_table #(
  parameter int IDX_W  = 3,
  parameter int ATTR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [IDX_W-1:0]  wr_base,
  input  logic [ATTR_W-1:0] wr_attr,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [IDX_W-1:0]  rd_base,
  output logic [ATTR_W-1:0] rd_attr
);
  localparam int NUM_ENT = 1 << IDX_W;

  logic [IDX_W-1:0]  base_q [NUM_ENT];
  logic [ATTR_W-1:0] attr_q [NUM_ENT];
  logic [NUM_ENT-1:0] wr_hit;

  always_comb begin
    for (int k = 0; k < NUM_ENT; k++) begin
      wr_hit[k] = wr_en && (wr_idx == IDX_W'(k));
    end
  end

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[g] <= IDX_W'(g);
        attr_q[g] <= ATTR_W'(rgn_pkg::ATTR_AT_RESET);
      end else if (wr_hit[g]) begin
        base_q[g] <= wr_base;
        attr_q[g] <= wr_attr;
      end
    end
  end

  assign rd_base = base_q[rd_idx];
  assign rd_attr = attr_q[rd_idx];

  // R8
  wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (base_q[$past(wr_idx)] == $past(wr_base)) &&
              (attr_q[$past(wr_idx)] == $past(wr_attr)));
endmodule

// File: rtl/rgn_attr_decode.sv
module rgn_attr_decode #(
  parameter int ATTR_W = 4
) (
  input  logic [ATTR_W-1:0] attr,
  output logic              can_rw,
  output logic              can_x
);
  localparam logic [ATTR_W-1:0] LIM   = ATTR_W'(6);
  localparam logic [ATTR_W-1:0] HOLE  = ATTR_W'(3);
  localparam logic [ATTR_W-1:0] EXTRA = ATTR_W'(14);

  always_comb begin
    can_rw = ((attr < LIM) && (attr != HOLE)) || (attr == EXTRA);
    can_x  = (attr != '0) && (attr < LIM);
  end
endmodule

// File: rtl/rgn_access_judge.sv
module rgn_access_judge #(
  parameter int CAUSE_W = 6
) (
  input  logic [1:0]         kind,
  input  logic [2:0]         perm,
  output logic               ok,
  output logic [CAUSE_W-1:0] cause
);
  import rgn_pkg::*;

  logic               need;
  logic [CAUSE_W-1:0] deny_code;

  always_comb begin
    unique case (kind)
      ACC_FETCH: begin
        need      = perm[PERM_X];
        deny_code = CAUSE_W'(CAUSE_FETCH_DENY);
      end
      ACC_WRITE: begin
        need      = perm[PERM_W];
        deny_code = CAUSE_W'(CAUSE_STORE_DENY);
      end
      default: begin
        need      = perm[PERM_R];
        deny_code = CAUSE_W'(CAUSE_LOAD_DENY);
      end
    endcase
    ok    = need;
    cause = need ? '0 : deny_code;
  end
endmodule

// File: rtl/rgn_xlate_unit.sv
module rgn_xlate_unit #(
  parameter int VA_W    = 32,
  parameter int IDX_W   = 3,
  parameter int ATTR_W  = 4,
  parameter int CAUSE_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic [1:0]         req_kind,
  input  logic               wr_en,
  input  logic               wr_itab,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [IDX_W-1:0]   wr_base,
  input  logic [ATTR_W-1:0]  wr_attr,
  output logic               rsp_valid,
  output logic [VA_W-1:0]    rsp_paddr,
  output logic [2:0]         rsp_perm,
  output logic               rsp_ok,
  output logic [CAUSE_W-1:0] rsp_cause
);
  import rgn_pkg::*;

  localparam int OFS_W = VA_W - IDX_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_in_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_in_n = rst_sync_q[1];

  logic [IDX_W-1:0]  reg_idx;
  logic [OFS_W-1:0]  reg_ofs;
  logic              is_fetch;
  logic [IDX_W-1:0]  ib_base, db_base, sel_base;
  logic [ATTR_W-1:0] ib_attr, db_attr, sel_attr;
  logic              can_rw, can_x;
  logic [2:0]        nxt_perm;
  logic              nxt_ok;
  logic [CAUSE_W-1:0] nxt_cause;
  logic [VA_W-1:0]   nxt_paddr;

  assign reg_idx  = req_vaddr[VA_W-1 -: IDX_W];
  assign reg_ofs  = req_vaddr[OFS_W-1:0];
  assign is_fetch = (req_kind == ACC_FETCH);

  rgn_table #(.IDX_W(IDX_W), .ATTR_W(ATTR_W)) u_itab (
    .clk(clk), .rst_n(rst_in_n),
    .wr_en(wr_en && wr_itab), .wr_idx(wr_idx), .wr_base(wr_base), .wr_attr(wr_attr),
    .rd_idx(reg_idx), .rd_base(ib_base), .rd_attr(ib_attr)
  );

  rgn_table #(.IDX_W(IDX_W), .ATTR_W(ATTR_W)) u_dtab (
    .clk(clk), .rst_n(rst_in_n),
    .wr_en(wr_en && !wr_itab), .wr_idx(wr_idx), .wr_base(wr_base), .wr_attr(wr_attr),
    .rd_idx(reg_idx), .rd_base(db_base), .rd_attr(db_attr)
  );

  assign sel_base = is_fetch ? ib_base : db_base;
  assign sel_attr = is_fetch ? ib_attr : db_attr;

  rgn_attr_decode #(.ATTR_W(ATTR_W)) u_dec (
    .attr(sel_attr), .can_rw(can_rw), .can_x(can_x)
  );

  always_comb begin
    nxt_perm         = '0;
    nxt_perm[PERM_R] = can_rw;
    nxt_perm[PERM_W] = can_rw;
    nxt_perm[PERM_X] = can_x;
    nxt_paddr        = {sel_base, reg_ofs};
  end

  rgn_access_judge #(.CAUSE_W(CAUSE_W)) u_judge (
    .kind(req_kind), .perm(nxt_perm), .ok(nxt_ok), .cause(nxt_cause)
  );

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_perm  <= '0;
      rsp_ok    <= 1'b0;
      rsp_cause <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_paddr <= nxt_paddr;
        rsp_perm  <= nxt_perm;
        rsp_ok    <= nxt_ok;
        rsp_cause <= nxt_cause;
      end
    end
  end

  // R9
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_in_n)
    req_valid |=> rsp_valid);

  // R9
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_in_n)
    !req_valid |=> !rsp_valid && $stable(rsp_paddr) && $stable(rsp_cause));

  // R5
  ok_cause_chk: assert property (@(posedge clk) disable iff (!rst_in_n)
    rsp_valid |-> (rsp_ok == (rsp_cause == '0)));

  // R6
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_in_n)
    req_valid |=> rsp_paddr[OFS_W-1:0] == $past(req_vaddr[OFS_W-1:0]));

  // R5
  fetch_uses_x_chk: assert property (@(posedge clk) disable iff (!rst_in_n)
    (req_valid && req_kind == ACC_FETCH) |=> (rsp_ok == rsp_perm[PERM_X]));
endmodule

// File: tb/tb_rgn_xlate_unit.sv
module tb_rgn_xlate_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic [1:0]  req_kind;
  logic        wr_en, wr_itab;
  logic [2:0]  wr_idx, wr_base;
  logic [3:0]  wr_attr;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_perm;
  logic        rsp_ok;
  logic [5:0]  rsp_cause;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [2:0] m_ibase [8];
  logic [3:0] m_iattr [8];
  logic [2:0] m_dbase [8];
  logic [3:0] m_dattr [8];

  always #5 clk = ~clk;

  rgn_xlate_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .wr_en(wr_en), .wr_itab(wr_itab), .wr_idx(wr_idx),
    .wr_base(wr_base), .wr_attr(wr_attr), .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm), .rsp_ok(rsp_ok), .rsp_cause(rsp_cause)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_perm(input logic [3:0] a);
    logic rw, x;
    rw = ((a < 4'd6) && (a != 4'd3)) || (a == 4'd14);
    x  = (a >= 4'd1) && (a <= 4'd5);
    return {x, rw, rw};
  endfunction

  function automatic logic [5:0] exp_cause(input logic [1:0] k, input logic [2:0] p);
    if (k == 2'd2) return p[2] ? 6'd0 : 6'd20;
    if (k == 2'd1) return p[1] ? 6'd0 : 6'd29;
    return p[0] ? 6'd0 : 6'd28;
  endfunction

  // compare the registered answer against the model for (va, k)
  task automatic expect_rsp(input string tag, input logic [31:0] va, input logic [1:0] k);
    logic [2:0] idx, b;
    logic [3:0] a;
    logic [2:0] p;
    idx = va[31:29];
    b = (k == 2'd2) ? m_ibase[idx] : m_dbase[idx];
    a = (k == 2'd2) ? m_iattr[idx] : m_dattr[idx];
    p = exp_perm(a);
    chk(tag, "valid", {31'd0, rsp_valid}, 32'd1);
    chk(tag, "paddr", rsp_paddr, {b, va[28:0]});
    chk(tag, "perm", {29'd0, rsp_perm}, {29'd0, p});
    chk(tag, "cause", {26'd0, rsp_cause}, {26'd0, exp_cause(k, p)});
    chk(tag, "ok", {31'd0, rsp_ok}, {31'd0, exp_cause(k, p) == 6'd0});
  endtask

  task automatic look(input string tag, input logic [31:0] va, input logic [1:0] k);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_kind = k;
    @(negedge clk);
    req_valid = 1'b0;
    expect_rsp(tag, va, k);
  endtask

  task automatic wr(input logic itab, input logic [2:0] i, input logic [2:0] b, input logic [3:0] a);
    @(negedge clk);
    wr_en = 1'b1; wr_itab = itab; wr_idx = i; wr_base = b; wr_attr = a;
    @(negedge clk);
    wr_en = 1'b0;
    if (itab) begin m_ibase[i] = b; m_iattr[i] = a; end
    else      begin m_dbase[i] = b; m_dattr[i] = a; end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] va, vb;
    logic [31:0] hold_pa;
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_kind = '0;
    wr_en = 1'b0; wr_itab = 1'b0; wr_idx = '0; wr_base = '0; wr_attr = '0;
    for (int i = 0; i < 8; i++) begin
      m_ibase[i] = 3'(i); m_dbase[i] = 3'(i); m_iattr[i] = 4'd2; m_dattr[i] = 4'd2;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R7 reset state of the outputs
    chk("R7", "valid", {31'd0, rsp_valid}, 32'd0);
    chk("R7", "paddr", rsp_paddr, 32'd0);
    chk("R7", "perm", {29'd0, rsp_perm}, 32'd0);
    chk("R7", "ok", {31'd0, rsp_ok}, 32'd0);
    chk("R7", "cause", {26'd0, rsp_cause}, 32'd0);

    // R7 R1 R6: default identity map with attribute 2, all kinds
    for (int r = 0; r < 8; r++)
      for (int k = 0; k < 4; k++)
        look("R7/R1/R6", {3'(r), 29'h1234567 ^ 29'(k * 29'h0ABCDEF)}, 2'(k));

    // R2 R3 R4 R5 R8: every attribute, tables given different attributes
    for (int a = 0; a < 16; a++) begin
      wr(1'b0, 3'd5, 3'd2, 4'(a));
      wr(1'b1, 3'd5, 3'd6, 4'(15 - a));
      for (int k = 0; k < 4; k++)
        look("R2/R3/R4/R5/R8", {3'd5, 29'(a * 29'h0111111 + k)}, 2'(k));
    end

    // R1 R6 R8: remap every region differently in each table
    for (int i = 0; i < 8; i++) begin
      wr(1'b0, 3'(i), 3'(7 - i), 4'(i));
      wr(1'b1, 3'(i), 3'(i) ^ 3'd3, 4'(i + 1));
    end
    for (int i = 0; i < 8; i++)
      for (int k = 0; k < 4; k++)
        look("R1/R6", {3'(i), 29'h1FFFFFFF - 29'(i * 29'h0333333)}, 2'(k));

    // R8: lookup in the same cycle as a write sees the old entry
    va = {3'd4, 29'h0A5A5A5};
    @(negedge clk);
    wr_en = 1'b1; wr_itab = 1'b0; wr_idx = 3'd4; wr_base = 3'd1; wr_attr = 4'd15;
    req_valid = 1'b1; req_vaddr = va; req_kind = 2'd0;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    expect_rsp("R8 same-cycle", va, 2'd0);
    m_dbase[4] = 3'd1; m_dattr[4] = 4'd15;
    look("R8 after", va, 2'd0);
    look("R8 after", va, 2'd1);

    // R9: idle cycle holds outputs and drops valid
    hold_pa = rsp_paddr;
    @(negedge clk);
    chk("R9 idle", "valid", {31'd0, rsp_valid}, 32'd0);
    chk("R9 idle", "paddr", rsp_paddr, hold_pa);

    // R9: back-to-back requests answered in order
    va = {3'd2, 29'h0000001};
    vb = {3'd6, 29'h1000000};
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_kind = 2'd2;
    @(negedge clk);
    req_vaddr = vb; req_kind = 2'd1;
    expect_rsp("R9 first", va, 2'd2);
    @(negedge clk);
    req_valid = 1'b0;
    expect_rsp("R9 second", vb, 2'd1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule